// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. It runs on the system clock, and a one-cycle enable pulse paces it at sixteen pulses per bit time. The line first passes through a two-flop synchronizer. The receiver waits for a high-to-low transition while idle and treats it as the leading edge of a start bit.

Each bit cell is then judged at its centre. The value of a cell is the majority of three consecutive enable-pulse samples taken there. A start bit that votes high is discarded as noise, and the receiver goes back to waiting. Otherwise it gathers five to eight data bits, least significant first, then an optional parity bit and one stop bit.

A completed character moves into a holding register. The line-status flags for that character are set at the same moment: data available, parity mismatch, bad stop bit, line break, and character lost through overrun. A read strobe on the data register clears the data-available flag. A read strobe on the status register clears the four error flags.

Top module: `uart_rx_core`

## Requirements
- R1: Reception starts only when the receiver is idle, an enable pulse occurs, and the synchronized line is 0 while its level at the previous enable pulse was 1. The serial input passes through two flip-flops, which reset to 1, before this test.
- R2: The enable pulse on which the edge is seen counts as pulse 0 of the start bit. Every bit cell lasts 16 enable pulses, and a cell is sampled on its pulses 7, 8 and 9.
- R3: A start bit whose vote is 1 ends the reception without producing a character. The holding register and all flags keep their values, and the next falling edge is accepted.
- R4: The value of each bit is the majority of its three samples, so a disturbance that corrupts one sample does not change the received character.
- R5: The character length is set by `cfg_len`: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant first. The byte is right-justified, with the unused upper bits 0.
- R6: When `cfg_par_en` is 1, one parity bit follows the data. With `cfg_par_even` = 1 the data bits and the parity bit must hold an even number of ones; with 0, an odd number. A mismatch sets `parity_err`.
- R7: A stop bit that votes 0 sets `framing_err`.
- R8: When every data bit, the parity bit (if enabled) and the stop bit all vote 0, `break_det` is set, along with `framing_err`.
- R9: A completed character is written to `rx_byte` and sets `data_ready`, both in the same clock cycle. `rd_data_strobe` clears `data_ready`.
- R10: A character that completes while `data_ready` is 1, with no data read in that cycle, replaces `rx_byte` and sets `overrun_err`.
- R11: `rd_status_strobe` clears `parity_err`, `framing_err`, `overrun_err` and `break_det`. A character completing in the same cycle takes priority and sets its own flags.
- R12: After reset, `rx_byte` is 0 and all five status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| cfg_len | input | 2 | Data bits minus five |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| rd_data_strobe | input | 1 | Data register read, clears data_ready |
| rd_status_strobe | input | 1 | Status register read, clears error flags |
| rx_byte | output | 8 | Holding register contents |
| data_ready | output | 1 | A character is waiting |
| parity_err | output | 1 | Parity mismatch seen |
| framing_err | output | 1 | Stop bit sampled low |
| overrun_err | output | 1 | Unread character overwritten |
| break_det | output | 1 | Line held low for a full frame |

## Verification
On every cycle, the assertions check four things. Reception begins only on an enable pulse with the line low. The bit-position counter moves only on enable pulses. A start cell never produces a character. The holding-register flags follow the load and clear rules, including overrun and the priority of a load over a status read.

Only the bench scenarios can show the rest: that the sampling point is really mid-cell, that a vote outvotes a single bad sample, and that a short low pulse is rejected. They also show that each length and parity mode produces the right byte, and how break differs from a plain framing fault. The bench shows these by sending whole frames and comparing the characters that come out.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              par_bad;
    logic              stop_bad;
    logic              brk;
  } rx_char_t;

  // number of data bits selected by the two-bit length code
  function automatic logic [3:0] char_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  // two-of-three vote
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // shift register fills from the top; move the character down to bit 0
  function automatic logic [CHAR_W-1:0] right_justify(input logic [CHAR_W-1:0] sr,
                                                      input logic [1:0] code);
    logic [CHAR_W-1:0] r;
    r = sr >> (4'd8 - char_bits(code));
    return r;
  endfunction

  // parity check result: 1 when the received parity bit disagrees
  function automatic logic parity_bad(input logic [CHAR_W-1:0] d, input logic pbit,
                                      input logic even);
    logic ones_odd;
    ones_odd = ^d ^ pbit;
    return even ? ones_odd : ~ones_odd;
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  output logic       load,
  output rx_char_t   char_out,
  output logic       busy
);

  localparam int CNT_W   = $clog2(OSR);
  localparam int MID     = OSR / 2;
  localparam logic [CNT_W-1:0] S_A  = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] S_B  = CNT_W'(MID);
  localparam logic [CNT_W-1:0] S_C  = CNT_W'(MID + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

  rx_state_e          state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [2:0]         idx_q;
  logic [CHAR_W-1:0]  sr_q;
  logic               va_q, vb_q;
  logic               prev_q;
  logic               zeros_q;
  logic               pbit_q;
  logic               load_q;
  rx_char_t           char_q;

  // named internal events
  logic start_edge;
  logic decide;
  logic cell_end;
  logic bit_val;
  logic last_data;
  logic [CHAR_W-1:0] aligned;

  assign start_edge = tick && (state_q == RX_IDLE) && prev_q && !line;
  assign decide     = tick && (state_q != RX_IDLE) && (cnt_q == S_C);
  assign cell_end   = tick && (state_q != RX_IDLE) && (cnt_q == LAST);
  assign bit_val    = vote3(va_q, vb_q, line);
  assign last_data  = ({1'b0, idx_q} == char_bits(cfg_len) - 4'd1);
  assign aligned    = right_justify(sr_q, cfg_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sr_q    <= '0;
      va_q    <= 1'b1;
      vb_q    <= 1'b1;
      prev_q  <= 1'b1;
      zeros_q <= 1'b0;
      pbit_q  <= 1'b0;
      load_q  <= 1'b0;
      char_q  <= '0;
    end else begin
      load_q <= 1'b0;
      if (state_q == RX_IDLE) begin
        if (tick) begin
          prev_q <= line;
          if (start_edge) begin
            state_q <= RX_START;
            cnt_q   <= CNT_W'(1);
            idx_q   <= '0;
            zeros_q <= 1'b1;
          end
        end
      end else if (tick) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == S_A) va_q <= line;
        if (cnt_q == S_B) vb_q <= line;
        if (decide) begin
          unique case (state_q)
            RX_START: begin
              if (bit_val) begin
                state_q <= RX_IDLE;
                prev_q  <= line;
              end
            end
            RX_DATA: begin
              sr_q    <= {bit_val, sr_q[CHAR_W-1:1]};
              zeros_q <= zeros_q & ~bit_val;
            end
            RX_PAR: begin
              pbit_q  <= bit_val;
              zeros_q <= zeros_q & ~bit_val;
            end
            RX_STOP: begin
              load_q          <= 1'b1;
              char_q.data     <= aligned;
              char_q.par_bad  <= cfg_par_en && parity_bad(aligned, pbit_q, cfg_par_even);
              char_q.stop_bad <= ~bit_val;
              char_q.brk      <= zeros_q & ~bit_val;
              state_q         <= RX_IDLE;
              prev_q          <= line;
            end
            default: ;
          endcase
        end
        if (cell_end) begin
          unique case (state_q)
            RX_START: begin
              state_q <= RX_DATA;
              idx_q   <= '0;
            end
            RX_DATA: begin
              if (last_data) state_q <= cfg_par_en ? RX_PAR : RX_STOP;
              else           idx_q   <= idx_q + 1'b1;
            end
            RX_PAR:  state_q <= RX_STOP;
            default: ;
          endcase
        end
      end
    end
  end

  assign load     = load_q;
  assign char_out = char_q;
  assign busy     = (state_q != RX_IDLE);

  // R1: leaving idle happens only on a pulse with the line low
  a_r1_start_on_low_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(tick) && !$past(line)));

  // R2: bit-position counter only moves on enable pulses
  a_r2_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(cnt_q));

  // R3: a start cell never yields a character
  a_r3_start_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START) |=> !load);

  // R9: a completion is a single-cycle pulse
  a_r9_load_single: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load);

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  rx_char_t          char_in,
  input  logic              rd_data,
  input  logic              rd_status,
  output logic [CHAR_W-1:0] byte_q,
  output logic              ready_q,
  output logic              pe_q,
  output logic              fe_q,
  output logic              oe_q,
  output logic              bi_q
);

  logic lost;
  assign lost = load && ready_q && !rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q  <= '0;
      ready_q <= 1'b0;
      pe_q    <= 1'b0;
      fe_q    <= 1'b0;
      oe_q    <= 1'b0;
      bi_q    <= 1'b0;
    end else begin
      if (load) begin
        byte_q  <= char_in.data;
        ready_q <= 1'b1;
      end else if (rd_data) begin
        ready_q <= 1'b0;
      end
      if (load) begin
        pe_q <= (pe_q & ~rd_status) | char_in.par_bad;
        fe_q <= (fe_q & ~rd_status) | char_in.stop_bad;
        bi_q <= (bi_q & ~rd_status) | char_in.brk;
        oe_q <= (oe_q & ~rd_status) | lost;
      end else if (rd_status) begin
        pe_q <= 1'b0;
        fe_q <= 1'b0;
        bi_q <= 1'b0;
        oe_q <= 1'b0;
      end
    end
  end

  // R9: a completed character always leaves data waiting
  a_r9_ready_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ready_q);

  // R10: overwriting unread data raises the overrun flag
  a_r10_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ready_q && !rd_data) |=> oe_q);

  // R11: a status read with no completion clears every error flag
  a_r11_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !load) |=> !(pe_q || fe_q || oe_q || bi_q));

  // R8: break implies framing fault
  a_r8_break_has_framing: assert property (@(posedge clk) disable iff (!rst_n)
    bi_q |-> fe_q);

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_serial,
  input  logic       os_tick,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       rd_data_strobe,
  input  logic       rd_status_strobe,
  output logic [7:0] rx_byte,
  output logic       data_ready,
  output logic       parity_err,
  output logic       framing_err,
  output logic       overrun_err,
  output logic       break_det
);

  logic     line_s;
  logic     char_load;
  logic     rx_busy;
  rx_char_t char_w;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_serial),
    .dout (line_s)
  );

  uart_rx_fsm #(.OSR(OSR)) i_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (os_tick),
    .line        (line_s),
    .cfg_len     (cfg_len),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_even(cfg_par_even),
    .load        (char_load),
    .char_out    (char_w),
    .busy        (rx_busy)
  );

  uart_rx_hold i_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (char_load),
    .char_in  (char_w),
    .rd_data  (rd_data_strobe),
    .rd_status(rd_status_strobe),
    .byte_q   (rx_byte),
    .ready_q  (data_ready),
    .pe_q     (parity_err),
    .fe_q     (framing_err),
    .oe_q     (overrun_err),
    .bi_q     (break_det)
  );

  // R12: nothing is reported while the receiver has never completed a frame
  a_r12_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> $past(char_load));

endmodule

// File: tb/test_uart_rx_core.sv
module test_uart_rx_core;

  localparam int BIT_CLKS = 64; // 16 pulses, one every 4 clocks

  typedef struct {
    logic [7:0] b;
    logic       pe;
    logic       fe;
    logic       bk;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_serial = 1'b1;
  logic       os_tick = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       rd_data_strobe = 1'b0;
  logic       rd_status_strobe = 1'b0;
  logic [7:0] rx_byte;
  logic       data_ready, parity_err, framing_err, overrun_err, break_det;

  int   n_checks = 0;
  int   n_fail = 0;
  int   cyc = 0;
  logic mon_en = 1'b1;
  logic dr_prev = 1'b0;
  exp_t expq[$];

  uart_rx_core i_uart_rx_core (
    .clk(clk), .rst_n(rst_n), .rx_serial(rx_serial), .os_tick(os_tick),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .rd_data_strobe(rd_data_strobe), .rd_status_strobe(rd_status_strobe),
    .rx_byte(rx_byte), .data_ready(data_ready), .parity_err(parity_err),
    .framing_err(framing_err), .overrun_err(overrun_err), .break_det(break_det)
  );

  always #5 clk = ~clk;

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv <= (tdiv + 1) % 4;
    os_tick <= (tdiv == 3);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  // monitor: compare each new character with the scoreboard
  always @(negedge clk) begin
    dr_prev <= data_ready;
    if (mon_en && data_ready && !dr_prev) begin
      if (expq.size() == 0) begin
        check(1'b0, "R9 unexpected character", rx_byte, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(rx_byte == e.b, "R5 byte", rx_byte, e.b);
        check(parity_err == e.pe, "R6 parity flag", parity_err, e.pe);
        check(framing_err == e.fe, "R7 framing flag", framing_err, e.fe);
        check(break_det == e.bk, "R8 break flag", break_det, e.bk);
        check(overrun_err == 1'b0, "R10 no overrun", overrun_err, 0);
      end
    end
  end

  task automatic drive_cell(input logic v, input bit glitch);
    for (int k = 0; k < BIT_CLKS; k++) begin
      @(negedge clk);
      rx_serial = (glitch && k >= 34 && k < 38) ? ~v : v;
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [1:0] len, input bit pen,
                            input bit even, input bit bad_par, input bit bad_stop,
                            input int glitch_bit, input bit push);
    int nb;
    logic [7:0] m;
    logic pb;
    exp_t e;
    nb = 5 + len;
    m = 8'hFF >> (8 - nb);
    pb = ^(d & m);
    if (!even) pb = ~pb;
    if (bad_par) pb = ~pb;
    cfg_len = len; cfg_par_en = pen; cfg_par_even = even;
    e.b  = d & m;
    e.pe = pen && bad_par;
    e.fe = bad_stop;
    e.bk = bad_stop && ((d & m) == 0) && (!pen || pb == 1'b0);
    if (push) expq.push_back(e);
    drive_cell(1'b0, 1'b0);
    for (int i = 0; i < nb; i++) drive_cell(d[i], glitch_bit == i);
    if (pen) drive_cell(pb, 1'b0);
    drive_cell(~bad_stop, 1'b0);
    @(negedge clk);
    rx_serial = 1'b1;
  endtask

  task automatic read_both();
    repeat (128) @(negedge clk);
    rd_data_strobe = 1'b1;
    rd_status_strobe = 1'b1;
    @(negedge clk);
    rd_data_strobe = 1'b0;
    rd_status_strobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check({rx_byte, data_ready, parity_err, framing_err, overrun_err, break_det} == 0,
          "R12 reset state", {rx_byte, data_ready}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1 R2 R5: plain 8-bit characters
    send_frame(8'hA5, 2'd3, 0, 0, 0, 0, -1, 1); read_both();
    send_frame(8'h3C, 2'd3, 0, 0, 0, 0, -1, 1); read_both();
    // R5: each shorter length
    send_frame(8'hFF, 2'd0, 0, 0, 0, 0, -1, 1); read_both();
    send_frame(8'hEA, 2'd1, 0, 0, 0, 0, -1, 1); read_both();
    send_frame(8'hD5, 2'd2, 0, 0, 0, 0, -1, 1); read_both();
    // R6: even and odd parity, good and bad
    send_frame(8'h71, 2'd3, 1, 1, 0, 0, -1, 1); read_both();
    send_frame(8'h71, 2'd3, 1, 1, 1, 0, -1, 1); read_both();
    send_frame(8'h13, 2'd2, 1, 0, 0, 0, -1, 1); read_both();
    send_frame(8'h13, 2'd2, 1, 0, 1, 0, -1, 1); read_both();
    // R4: one corrupted sample in a data cell is outvoted
    send_frame(8'hFF, 2'd3, 0, 0, 0, 0, 3, 1); read_both();
    send_frame(8'h00, 2'd3, 0, 0, 0, 0, 5, 1); read_both();
    // R7: bad stop, nonzero data: framing only
    send_frame(8'h55, 2'd3, 0, 0, 0, 1, -1, 1); read_both();
    // R8: all-zero frame with low stop: break
    send_frame(8'h00, 2'd3, 1, 1, 0, 1, -1, 1); read_both();
    // R11: status read cleared the flags
    check(!(parity_err || framing_err || break_det || overrun_err), "R11 flags cleared",
          {parity_err, framing_err, break_det, overrun_err}, 0);
    // R9: data read cleared ready
    check(data_ready == 1'b0, "R9 ready cleared", data_ready, 0);

    // R3: short low pulse is a false start
    @(negedge clk); rx_serial = 1'b0;
    repeat (20) @(negedge clk); rx_serial = 1'b1;
    repeat (3 * BIT_CLKS * 10) @(negedge clk);
    check(data_ready == 1'b0, "R3 false start gives no character", data_ready, 0);
    check(rx_byte == 8'h00, "R3 holding register kept", rx_byte, 0);
    send_frame(8'h96, 2'd3, 0, 0, 0, 0, -1, 1); read_both();

    // R10: two characters without a read
    mon_en = 1'b0;
    send_frame(8'h11, 2'd3, 0, 0, 0, 0, -1, 0);
    repeat (64) @(negedge clk);
    send_frame(8'h22, 2'd3, 0, 0, 0, 0, -1, 0);
    repeat (128) @(negedge clk);
    check(rx_byte == 8'h22, "R10 newest byte kept", rx_byte, 8'h22);
    check(overrun_err == 1'b1, "R10 overrun set", overrun_err, 1);
    check(data_ready == 1'b1, "R10 ready still set", data_ready, 1);
    @(negedge clk); rd_status_strobe = 1'b1;
    @(negedge clk); rd_status_strobe = 1'b0;
    check(overrun_err == 1'b0, "R11 overrun cleared", overrun_err, 0);
    check(data_ready == 1'b1, "R11 status read leaves ready", data_ready, 1);
    @(negedge clk); rd_data_strobe = 1'b1;
    @(negedge clk); rd_data_strobe = 1'b0;
    check(data_ready == 1'b0, "R9 data read clears ready", data_ready, 0);

    check(expq.size() == 0, "R9 all expected characters seen", expq.size(), 0);
    finish_run();
  end

endmodule